// File: doc/BRIEF.md
# Single-Operand ALU with Condition Codes

This block is the purely combinational execution stage for the single-operand arithmetic, rotate and shift group of a 16-bit minicomputer instruction set. The decode stage hands it the instruction word, an operand that has already been fetched, and the current carry flag. In the same cycle the block returns the result, a strobe that says whether to write that result back, and new N, Z, V and C values. A four-bit mask goes with the flags and marks which of them the instruction updates.

Both word and byte forms are decoded. A byte operation works only on the low eight bits of the operand. Its flags come from bit 7 and the low byte, and the upper byte of the operand passes through to the result unchanged. The byte-swap instruction is also handled here. Operand fetch, addressing, the register file and the two-operand instructions all live elsewhere.

Top module: `sop_alu`

## Requirements
- R1: The block recognises an instruction only in two cases: bits 14:12 are zero and bits 11:6 lie in octal 50..63, or bits 15:6 equal octal 0003. Any other instruction gives wr_en=0, flag_upd=0000 and result equal to the operand. The mask is ordered [3]=N, [2]=Z, [1]=V, [0]=C. A flag whose mask bit is 0 reads 0 for N, Z and V, and equals c_in for C.
- R2: Bit 15 of the instruction selects byte mode when it is 1. Byte results take N from bit 7 and Z from the low byte. Byte results keep result[15:8] equal to opnd[15:8].
- R3: Sub-op 50 (clear) produces a zero result and NZVC=0100, with all four flags updated.
- R4: Sub-op 51 (complement) inverts the operand, sets V=0 and C=1, and takes N and Z from the result.
- R5: Sub-op 52 (increment) sets V only when the operand is the largest positive value. Sub-op 53 (decrement) sets V only when the operand is the most negative value. Both use mask 1110, so C is kept.
- R6: Sub-op 54 (negate) gives the two's complement of the operand. C=1 unless the result is zero, and V=1 only when the result is the most negative value.
- R7: Sub-op 55 adds c_in to the operand. It sets C when the operand is all ones and c_in=1, and sets V when the operand is the largest positive value and c_in=1. Sub-op 56 subtracts c_in. It sets C when the operand is zero and c_in=1, and sets V when the operand is the most negative value and c_in=1.
- R8: Sub-ops 60 and 61 rotate the ring {c_in, operand} right or left by one place; the ring is 17 bits wide for words and 9 bits for bytes. The bit that leaves the operand becomes C.
- R9: Sub-op 62 shifts right and keeps the sign bit. Sub-op 63 shifts left and fills the vacated bit with 0. The bit shifted out becomes C. For every rotate and shift, V equals N XOR C.
- R10: Sub-op 57 (test) writes nothing. It takes N and Z from the operand and clears V and C.
- R11: Byte swap exchanges the two operand bytes. It takes N and Z from the new low byte and clears V and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| opnd | input | 16 | Fetched operand |
| c_in | input | 1 | Current carry flag |
| result | output | 16 | Result value |
| wr_en | output | 1 | Write the result back |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_v | output | 1 | New overflow flag |
| flag_c | output | 1 | New carry flag |
| flag_upd | output | 4 | Flags to update, [3]=N..[0]=C |

## Verification
Byte mode and carry propagation act together in a single evaluation. A byte rotate, for instance, must insert c_in at bit 7 while also holding the upper byte and taking N from bit 7. The bench drives byte rotates, byte shifts and byte add-carry on operands whose upper byte differs from the low byte. It judges the whole 16-bit result together with NZVC against values worked out by hand.

// File: rtl/sop_alu.sv
module sop_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] instr,
  input  logic [DW-1:0] opnd,
  input  logic          c_in,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c,
  output logic [3:0]    flag_upd
);
  localparam int HB = DW / 2;

  localparam logic [5:0] OP_CLR = 6'o50, OP_COM = 6'o51, OP_INC = 6'o52,
                         OP_DEC = 6'o53, OP_NEG = 6'o54, OP_ADC = 6'o55,
                         OP_SBC = 6'o56, OP_TST = 6'o57, OP_ROR = 6'o60,
                         OP_ROL = 6'o61, OP_ASR = 6'o62, OP_ASL = 6'o63;

  wire          byte_md = instr[DW-1];
  wire [5:0]    op      = instr[11:6];
  wire          in_grp  = (instr[14:12] == 3'b000) && (op >= OP_CLR) && (op <= OP_ASL);
  wire          is_swab = (instr[DW-1:6] == 10'o0003);

  wire [DW-1:0] lo_mask = byte_md ? {{HB{1'b0}}, {HB{1'b1}}} : {DW{1'b1}};
  wire [DW-1:0] maxpos  = lo_mask >> 1;
  wire [DW-1:0] minneg  = lo_mask ^ maxpos;
  wire [DW-1:0] a       = opnd & lo_mask;
  wire          a_msb   = |(a & minneg);

  logic [DW-1:0] r;
  logic          cn, vn, we;
  logic [3:0]    upd;
  logic          sh;

  always_comb begin
    r   = a;
    cn  = c_in;
    vn  = 1'b0;
    we  = 1'b1;
    upd = 4'b1111;
    sh  = 1'b0;
    case (op)
      OP_CLR: begin r = '0; cn = 1'b0; end
      OP_COM: begin r = ~a & lo_mask; cn = 1'b1; end
      OP_INC: begin r = (a + 1'b1) & lo_mask; vn = (a == maxpos); upd = 4'b1110; end
      OP_DEC: begin r = (a - 1'b1) & lo_mask; vn = (a == minneg); upd = 4'b1110; end
      OP_NEG: begin
        r  = (~a + 1'b1) & lo_mask;
        cn = (r != '0);
        vn = (r == minneg);
      end
      OP_ADC: begin
        r  = (a + {{(DW-1){1'b0}}, c_in}) & lo_mask;
        cn = c_in && (a == lo_mask);
        vn = c_in && (a == maxpos);
      end
      OP_SBC: begin
        r  = (a - {{(DW-1){1'b0}}, c_in}) & lo_mask;
        cn = c_in && (a == '0);
        vn = c_in && (a == minneg);
      end
      OP_TST: begin we = 1'b0; cn = 1'b0; end
      OP_ROR: begin r = (a >> 1) | (c_in ? minneg : '0); cn = a[0]; sh = 1'b1; end
      OP_ROL: begin r = ((a << 1) & lo_mask) | {{(DW-1){1'b0}}, c_in}; cn = a_msb; sh = 1'b1; end
      OP_ASR: begin r = (a >> 1) | (a_msb ? minneg : '0); cn = a[0]; sh = 1'b1; end
      OP_ASL: begin r = (a << 1) & lo_mask; cn = a_msb; sh = 1'b1; end
      default: begin we = 1'b0; upd = 4'b0000; end
    endcase
  end

  wire rn = |(r & minneg);
  wire rz = ((r & lo_mask) == '0);

  wire [DW-1:0] swapped = {opnd[HB-1:0], opnd[DW-1:HB]};
  wire [DW-1:0] grp_res = byte_md ? {opnd[DW-1:HB], r[HB-1:0]} : r;

  always_comb begin
    if (is_swab) begin
      result   = swapped;
      wr_en    = 1'b1;
      flag_upd = 4'b1111;
      flag_n   = swapped[HB-1];
      flag_z   = (swapped[HB-1:0] == '0);
      flag_v   = 1'b0;
      flag_c   = 1'b0;
    end else if (in_grp) begin
      result   = we ? grp_res : opnd;
      wr_en    = we;
      flag_upd = upd;
      flag_n   = rn;
      flag_z   = rz;
      flag_v   = sh ? (rn ^ cn) : vn;
      flag_c   = cn;
    end else begin
      result   = opnd;
      wr_en    = 1'b0;
      flag_upd = 4'b0000;
      flag_n   = 1'b0;
      flag_z   = 1'b0;
      flag_v   = 1'b0;
      flag_c   = c_in;
    end
  end
endmodule

// File: rtl/sop_alu_chk.sv
module sop_alu_chk (
  input logic [15:0] instr,
  input logic [15:0] opnd,
  input logic        c_in,
  input logic [15:0] result,
  input logic        wr_en,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_v,
  input logic        flag_c,
  input logic [3:0]  flag_upd
);
  wire       grp  = instr[14:12] == 3'b000;
  wire [5:0] sub  = instr[11:6];
  wire       swab = instr[15:6] == 10'o0003;
  wire       known = swab || (grp && sub >= 6'o50 && sub <= 6'o63);
  wire       shop = grp && sub >= 6'o60 && sub <= 6'o63;

  always_comb begin
    if (!known) begin
      a_r1_unknown_idle: assert (!wr_en && flag_upd == 4'b0000 && result == opnd && flag_c == c_in);
    end
    if (known && !swab && instr[15] && wr_en) begin
      a_r2_byte_upper: assert (result[15:8] == opnd[15:8]);
    end
    if (grp && (sub == 6'o52 || sub == 6'o53)) begin
      a_r5_keep_carry: assert (flag_upd == 4'b1110 && flag_c == c_in);
    end
    if (shop) begin
      a_r9_shift_v: assert (flag_v == (flag_n ^ flag_c));
    end
    if (grp && sub == 6'o57) begin
      a_r10_no_write: assert (!wr_en && !flag_v && !flag_c);
    end
  end
endmodule

bind sop_alu sop_alu_chk u_chk (
  .instr(instr), .opnd(opnd), .c_in(c_in), .result(result), .wr_en(wr_en),
  .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
  .flag_upd(flag_upd)
);

// File: tb/sop_alu_tb.sv
module sop_alu_tb;
  logic clk = 0;
  always #10 clk = ~clk;

  logic [15:0] instr, opnd, result;
  logic        c_in, wr_en, fn, fz, fv, fc;
  logic [3:0]  upd;
  int checks = 0, errors = 0;

  sop_alu u_dut (
    .instr(instr), .opnd(opnd), .c_in(c_in), .result(result), .wr_en(wr_en),
    .flag_n(fn), .flag_z(fz), .flag_v(fv), .flag_c(fc), .flag_upd(upd)
  );

  function automatic logic [15:0] mk(input logic b, input logic [5:0] sub);
    return {b, 3'b000, sub, 6'o27};
  endfunction

  task automatic run(input string tag, input logic [15:0] ins, input logic [15:0] op,
                     input logic ci, input logic [15:0] eres, input logic ewe,
                     input logic [3:0] eupd, input logic [3:0] enzvc);
    @(negedge clk);
    instr = ins; opnd = op; c_in = ci;
    #5;
    checks++;
    if (result !== eres || wr_en !== ewe || upd !== eupd || {fn, fz, fv, fc} !== enzvc) begin
      errors++;
      $display("FAIL %s: res=%h we=%b upd=%b nzvc=%b expected res=%h we=%b upd=%b nzvc=%b",
               tag, result, wr_en, upd, {fn, fz, fv, fc}, eres, ewe, eupd, enzvc);
    end
  endtask

  task automatic t_idle;
    run("R1 idle", 16'o000400, 16'h1234, 1'b1, 16'h1234, 0, 4'b0000, 4'b0001);
    run("R1 high group", 16'o015000, 16'hBEEF, 1'b0, 16'hBEEF, 0, 4'b0000, 4'b0000);
    run("R1 byte swab code", 16'o100300, 16'h80FF, 1'b1, 16'h80FF, 0, 4'b0000, 4'b0001);
  endtask

  task automatic t_clear_com;
    run("R3 clr word", mk(0, 6'o50), 16'h1234, 1'b1, 16'h0000, 1, 4'b1111, 4'b0100);
    run("R3 R2 clr byte", mk(1, 6'o50), 16'hABCD, 1'b1, 16'hAB00, 1, 4'b1111, 4'b0100);
    run("R4 com word", mk(0, 6'o51), 16'h00FF, 1'b0, 16'hFF00, 1, 4'b1111, 4'b1001);
    run("R4 R2 com byte", mk(1, 6'o51), 16'h12FF, 1'b0, 16'h1200, 1, 4'b1111, 4'b0101);
  endtask

  task automatic t_incdec;
    run("R5 inc word max", mk(0, 6'o52), 16'h7FFF, 1'b0, 16'h8000, 1, 4'b1110, 4'b1010);
    run("R5 R2 inc byte max", mk(1, 6'o52), 16'h557F, 1'b1, 16'h5580, 1, 4'b1110, 4'b1011);
    run("R5 dec word min", mk(0, 6'o53), 16'h8000, 1'b1, 16'h7FFF, 1, 4'b1110, 4'b0011);
    run("R5 dec word to zero", mk(0, 6'o53), 16'h0001, 1'b0, 16'h0000, 1, 4'b1110, 4'b0100);
  endtask

  task automatic t_neg;
    run("R6 neg one", mk(0, 6'o54), 16'h0001, 1'b0, 16'hFFFF, 1, 4'b1111, 4'b1001);
    run("R6 neg zero", mk(0, 6'o54), 16'h0000, 1'b1, 16'h0000, 1, 4'b1111, 4'b0100);
    run("R6 neg min", mk(0, 6'o54), 16'h8000, 1'b0, 16'h8000, 1, 4'b1111, 4'b1011);
    run("R6 R2 neg byte min", mk(1, 6'o54), 16'h3480, 1'b0, 16'h3480, 1, 4'b1111, 4'b1011);
  endtask

  task automatic t_carry;
    run("R7 adc wrap", mk(0, 6'o55), 16'hFFFF, 1'b1, 16'h0000, 1, 4'b1111, 4'b0101);
    run("R7 adc ovf", mk(0, 6'o55), 16'h7FFF, 1'b1, 16'h8000, 1, 4'b1111, 4'b1010);
    run("R7 adc no carry", mk(0, 6'o55), 16'h1234, 1'b0, 16'h1234, 1, 4'b1111, 4'b0000);
    run("R7 R2 adc byte wrap", mk(1, 6'o55), 16'h12FF, 1'b1, 16'h1200, 1, 4'b1111, 4'b0101);
    run("R7 sbc borrow", mk(0, 6'o56), 16'h0000, 1'b1, 16'hFFFF, 1, 4'b1111, 4'b1001);
    run("R7 sbc ovf", mk(0, 6'o56), 16'h8000, 1'b1, 16'h7FFF, 1, 4'b1111, 4'b0010);
  endtask

  task automatic t_rotate;
    run("R8 ror out", mk(0, 6'o60), 16'h0001, 1'b0, 16'h0000, 1, 4'b1111, 4'b0111);
    run("R8 ror in", mk(0, 6'o60), 16'h0000, 1'b1, 16'h8000, 1, 4'b1111, 4'b1010);
    run("R8 rol out", mk(0, 6'o61), 16'h8000, 1'b0, 16'h0000, 1, 4'b1111, 4'b0111);
    run("R8 R2 rol byte", mk(1, 6'o61), 16'hFF40, 1'b1, 16'hFF81, 1, 4'b1111, 4'b1010);
    run("R8 R2 ror byte", mk(1, 6'o60), 16'h0003, 1'b1, 16'h0081, 1, 4'b1111, 4'b1001);
  endtask

  task automatic t_shift;
    run("R9 asr word", mk(0, 6'o62), 16'h8001, 1'b0, 16'hC000, 1, 4'b1111, 4'b1001);
    run("R9 asl word", mk(0, 6'o63), 16'h4000, 1'b1, 16'h8000, 1, 4'b1111, 4'b1010);
    run("R9 R2 asl byte", mk(1, 6'o63), 16'h11C0, 1'b0, 16'h1180, 1, 4'b1111, 4'b1001);
    run("R9 R2 asr byte", mk(1, 6'o62), 16'h0081, 1'b0, 16'h00C0, 1, 4'b1111, 4'b1001);
  endtask

  task automatic t_test_swab;
    run("R10 tst word", mk(0, 6'o57), 16'h8000, 1'b1, 16'h8000, 0, 4'b1111, 4'b1000);
    run("R10 R2 tst byte", mk(1, 6'o57), 16'h7F00, 1'b1, 16'h7F00, 0, 4'b1111, 4'b0100);
    run("R11 swab neg", 16'o000300, 16'h80FF, 1'b1, 16'hFF80, 1, 4'b1111, 4'b1000);
    run("R11 swab zero", 16'o000312, 16'h00AB, 1'b1, 16'hAB00, 1, 4'b1111, 4'b0100);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    instr = '0; opnd = '0; c_in = 0;
    t_idle;
    t_clear_com;
    t_incdec;
    t_neg;
    t_carry;
    t_rotate;
    t_shift;
    t_test_swab;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule